// File: doc/BRIEF.md
# Serial ADC Output Shifter

This block is the device-side serial output stage of a sampling converter. A host supplies a serial clock and an active-low select line. Each select assertion captures a parallel conversion result (12 bits by default, 10 bits through a parameter) and sends it out as a 16-bit frame on a tri-statable data pin. The frame is two leading zeros, then the result MSB first, then zeros to fill 16 bits. The block also drives the track/hold control of the sampling stage and gives one-cycle pulses when a conversion completes or is cut short.

The design is FPGA-minded. The serial clock and the select line are oversampled by a fast system clock `clk` through a synchronizer of `SYNC_STAGES` flops, then passed through an edge detector. Every output is registered in the `clk` domain. Each reaction to a pin edge therefore appears a fixed number of `clk` cycles after that edge. The serial clock idles high between frames, so the first edge after select falls is a falling edge. The parallel input `result_i` must be stable while the select falling edge passes through the synchronizer.

Top module: `adc_serial_shifter`

## Requirements
- R1: After a synchronous reset, `dout_oe` is 0, `track_o` is 1 (track mode), and `done_o` and `abort_o` are 0.
- R2: A falling edge on `sel_n_i` sets `track_o` to 0 (hold), sets `dout_oe` to 1, and puts the first leading zero (`dout_o` = 0) on the pin before any serial clock edge.
- R3: Serial clock falling edge number k (k = 1..15) puts frame bit k on `dout_o`. Bits 0 and 1 are zero, bits 2..DATA_W+1 carry `result` MSB first, and the remaining bits are zero. Rising edges leave `dout_o` unchanged.
- R4: `track_o` returns to 1 on the first serial clock rising edge after DATA_W+1 falling edges (13 for 12-bit). At that moment `done_o` pulses high for exactly one `clk` cycle.
- R5: On the 16th falling edge of a frame, `dout_oe` drops to 0. Further falling edges before the select line rises leave it at 0.
- R6: If `sel_n_i` rises while the block is still in hold mode, the conversion is aborted: `dout_oe` goes to 0, `track_o` goes to 1, `abort_o` pulses for one cycle, and `done_o` does not pulse.
- R7: A rise of `sel_n_i` after the conversion has completed (for example after 14 falling edges) sets `dout_oe` to 0 with no `abort_o` pulse.
- R8: The result word is captured at the select falling edge. Changes on `result_i` during the frame do not alter the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock from the host, idle high |
| sel_n_i | input | 1 | Active-low frame select from the host |
| result_i | input | DATA_W | Parallel conversion result |
| dout_o | output | 1 | Serial data bit |
| dout_oe | output | 1 | Output enable for the data pad (0 = high impedance) |
| track_o | output | 1 | 1 = track mode, 0 = hold mode |
| done_o | output | 1 | One-cycle pulse when a conversion completes |
| abort_o | output | 1 | One-cycle pulse when a conversion is aborted |

## Verification
A pin edge driven just after a `clk` falling edge is first sampled at the next rising edge. With two synchronizer stages, the registered outputs change two rising edges later. The bench therefore holds every serial level for eight `clk` cycles and queues its expectation six cycles after the edge, well past that point and before the next edge. The done and abort pulses last one cycle, so they are counted on every `clk` rising edge. The counts are compared after each select release rather than sampled at a single instant.

// File: rtl/adc_shift_pkg.sv
package adc_shift_pkg;

  // level and one-cycle edge flags of an oversampled pin
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } pin_ev_t;

endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync
  import adc_shift_pkg::*;
#(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    pin_i,
  output pin_ev_t ev_o
);

  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= IDLE;
        else     chain[0] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= IDLE;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE;
    else     prev <= chain[STAGES-1];
  end

  always_comb begin
    ev_o.lvl  = chain[STAGES-1];
    ev_o.rise = chain[STAGES-1] & ~prev;
    ev_o.fall = ~chain[STAGES-1] & prev;
  end

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_shift_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int FRAME_LEN = 16
) (
  input  logic    clk,
  input  logic    rst,
  input  pin_ev_t sclk_ev,
  input  pin_ev_t sel_ev,
  output logic    load_o,
  output logic    shift_o,
  output logic    oe_o,
  output logic    track_o,
  output logic    done_o,
  output logic    abort_o
);

  localparam int CNT_W       = $clog2(FRAME_LEN + 1);
  localparam int TRACK_AFTER = DATA_W + 1;

  logic             active;
  logic [CNT_W-1:0] fall_cnt;
  logic             cnt_room;

  assign cnt_room = fall_cnt < CNT_W'(FRAME_LEN);
  assign load_o   = sel_ev.fall;
  assign shift_o  = active & sclk_ev.fall & cnt_room & ~sel_ev.fall & ~sel_ev.rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      fall_cnt <= '0;
      oe_o     <= 1'b0;
      track_o  <= 1'b1;
      done_o   <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      abort_o <= 1'b0;
      if (sel_ev.fall) begin
        active   <= 1'b1;
        fall_cnt <= '0;
        oe_o     <= 1'b1;
        track_o  <= 1'b0;
      end else if (sel_ev.rise) begin
        active  <= 1'b0;
        oe_o    <= 1'b0;
        track_o <= 1'b1;
        if (!track_o) abort_o <= 1'b1;
      end else if (active) begin
        if (sclk_ev.fall && cnt_room) begin
          fall_cnt <= fall_cnt + 1'b1;
          if (fall_cnt == CNT_W'(FRAME_LEN - 1)) oe_o <= 1'b0;
        end
        if (sclk_ev.rise && !track_o && fall_cnt >= CNT_W'(TRACK_AFTER)) begin
          track_o <= 1'b1;
          done_o  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/adc_frame_shreg.sv
module adc_frame_shreg #(
  parameter int DATA_W    = 12,
  parameter int FRAME_LEN = 16,
  parameter int LEAD      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              bit_o
);

  localparam int TRAIL = FRAME_LEN - LEAD - DATA_W;

  logic [FRAME_LEN-1:0] sreg;
  logic [FRAME_LEN-1:0] frame;

  assign frame = FRAME_LEN'(result_i) << TRAIL;

  always_ff @(posedge clk) begin
    if (rst)          sreg <= '0;
    else if (load_i)  sreg <= frame;
    else if (shift_i) sreg <= {sreg[FRAME_LEN-2:0], 1'b0};
  end

  assign bit_o = sreg[FRAME_LEN-1];

endmodule

// File: rtl/adc_serial_shifter.sv
module adc_serial_shifter
  import adc_shift_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int FRAME_LEN   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              sel_n_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              dout_o,
  output logic              dout_oe,
  output logic              track_o,
  output logic              done_o,
  output logic              abort_o
);

  localparam int LEAD = 2;

  pin_ev_t sclk_ev;
  pin_ev_t sel_ev;
  logic    load;
  logic    shift;

  adc_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sclk_sync (
    .clk(clk), .rst(rst), .pin_i(ser_clk_i), .ev_o(sclk_ev)
  );

  adc_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sel_sync (
    .clk(clk), .rst(rst), .pin_i(sel_n_i), .ev_o(sel_ev)
  );

  adc_frame_seq #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u_seq (
    .clk(clk), .rst(rst), .sclk_ev(sclk_ev), .sel_ev(sel_ev),
    .load_o(load), .shift_o(shift), .oe_o(dout_oe), .track_o(track_o),
    .done_o(done_o), .abort_o(abort_o)
  );

  adc_frame_shreg #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .LEAD(LEAD)) u_shreg (
    .clk(clk), .rst(rst), .load_i(load), .shift_i(shift),
    .result_i(result_i), .bit_o(dout_o)
  );

endmodule

// File: rtl/adc_shifter_chk.sv
module adc_shifter_chk (
  input logic clk,
  input logic rst,
  input logic dout_o,
  input logic dout_oe,
  input logic track_o,
  input logic done_o,
  input logic abort_o
);

  // R2
  hold_drives_pin_chk: assert property (@(posedge clk) disable iff (rst)
    !track_o |-> dout_oe);

  // R2
  hold_start_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(track_o) |-> (dout_oe && !dout_o));

  // R4
  done_on_track_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $rose(track_o));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6
  abort_release_chk: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (track_o && !dout_oe && !done_o));

  // R6
  abort_single_chk: assert property (@(posedge clk) disable iff (rst)
    abort_o |=> !abort_o);

endmodule

bind adc_serial_shifter adc_shifter_chk u_chk (
  .clk(clk), .rst(rst), .dout_o(dout_o), .dout_oe(dout_oe),
  .track_o(track_o), .done_o(done_o), .abort_o(abort_o)
);

// File: tb/adc_serial_shifter_tb.sv
module adc_serial_shifter_tb;

  localparam int DATA_W = 12;
  localparam int HALF   = 8;
  localparam int SETTLE = 6;

  typedef struct {
    logic  oe;
    logic  d;
    logic  trk;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk_i = 1'b1;
  logic sel_n_i = 1'b1;
  logic [DATA_W-1:0] result_i = '0;
  logic dout_o, dout_oe, track_o, done_o, abort_o;

  int n_chk = 0;
  int n_fail = 0;
  int n_done = 0;
  int n_abort = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  adc_serial_shifter #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk_i), .sel_n_i(sel_n_i),
    .result_i(result_i), .dout_o(dout_o), .dout_oe(dout_oe),
    .track_o(track_o), .done_o(done_o), .abort_o(abort_o)
  );

  always @(posedge clk) begin
    if (!rst && done_o)  n_done++;
    if (!rst && abort_o) n_abort++;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      check(dout_oe === it.oe, it.tag, "dout_oe", int'(dout_oe), int'(it.oe));
      check(track_o === it.trk, it.tag, "track_o", int'(track_o), int'(it.trk));
      if (it.oe) check(dout_o === it.d, it.tag, "dout_o", int'(dout_o), int'(it.d));
    end
  end

  function automatic logic frame_bit(input logic [DATA_W-1:0] w, input int k);
    if (k < 2 || k >= 2 + DATA_W) return 1'b0;
    return w[DATA_W-1-(k-2)];
  endfunction

  task automatic push(input logic oe, input logic d, input logic trk, input string tag);
    exp_t it;
    it.oe = oe; it.d = d; it.trk = trk; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic run_frame(input logic [DATA_W-1:0] w, input int nfall, input bit mid_change);
    logic trk = 1'b0;
    int d0 = n_done;
    int a0 = n_abort;
    result_i = w;
    @(negedge clk) sel_n_i = 1'b0;
    settle();
    push(1'b1, 1'b0, 1'b0, "R2");
    repeat (HALF - SETTLE) @(negedge clk);
    if (mid_change) result_i = ~w;
    for (int k = 1; k <= nfall; k++) begin
      ser_clk_i = 1'b0;
      settle();
      push(k < 16, frame_bit(w, k), trk, mid_change ? "R8" : (k >= 16 ? "R5" : "R3"));
      repeat (HALF - SETTLE) @(negedge clk);
      ser_clk_i = 1'b1;
      if (k >= DATA_W + 1) trk = 1'b1;
      settle();
      push(k < 16, frame_bit(w, k), trk, "R4");
      repeat (HALF - SETTLE) @(negedge clk);
    end
    sel_n_i = 1'b1;
    settle();
    push(1'b0, 1'b0, 1'b1, nfall >= DATA_W + 1 ? "R7" : "R6");
    repeat (HALF) @(negedge clk);
    if (nfall >= DATA_W + 1) begin
      check(n_done == d0 + 1, "R4", "done pulses", n_done - d0, 1);
      check(n_abort == a0, "R7", "abort pulses", n_abort - a0, 0);
    end else begin
      check(n_done == d0, "R6", "done pulses", n_done - d0, 0);
      check(n_abort == a0 + 1, "R6", "abort pulses", n_abort - a0, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(dout_oe === 1'b0, "R1", "dout_oe", int'(dout_oe), 0);
    check(track_o === 1'b1, "R1", "track_o", int'(track_o), 1);
    check(done_o === 1'b0 && abort_o === 1'b0, "R1", "pulses", int'(done_o | abort_o), 0);
    repeat (4) @(negedge clk);

    run_frame(12'hA5C, 16, 1'b0);
    run_frame(12'hFFF, 16, 1'b0);
    run_frame(12'h801, 14, 1'b0);
    run_frame(12'h3F1, 16, 1'b1);
    run_frame(12'h5A5, 5, 1'b0);
    run_frame(12'h001, 13, 1'b0);
    run_frame(12'hC3C, 18, 1'b0);
    run_frame(12'h7FF, 12, 1'b0);
    run_frame(12'h000, 16, 1'b0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule